// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by fetching translation entries from a two-level table held in memory. A request carries the linear address, a write flag, the current privilege level, a privilege override, a write-protect enable and a large-page enable, together with the table base. The walker reads the top-level (directory) entry and, for ordinary 4 KiB pages, the second-level (table) entry. It applies the presence and permission rules and returns either a physical address or a page fault. A fault carries an error code and the faulting linear address.

After a successful walk the walker stores the accessed and dirty marks back into the entries it used. It does this with two writes on the same memory port. A walk that fails stores nothing. The block handles one translation at a time. `busy` is high for the whole walk, and each result appears on a one-cycle `rspValid` pulse. When an abort is already pending at request time, no walk is started and an all-ones invalid result is returned.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read at (tableBase with bits 11:0 cleared) + linear[31:22]*4. The table entry is read at (directory entry with bits 11:0 cleared) + linear[21:12]*4. The address is held steady until `memAck`.
- R2: For a 4 KiB page the physical address is table entry bits 31:12 followed by linear bits 11:0. Entry bit 0 means present, bit 1 writable, bit 2 user-accessible and bit 7 page-size.
- R3: When directory bit 7 is set and `largePageEn` is 1, no table entry is read. The physical address is then directory bits 31:22 followed by linear bits 21:0, and the permissions come from the directory entry alone. With `largePageEn` 0, bit 7 is ignored and the table is walked.
- R4: A directory entry with bit 0 clear ends the walk after one read. A table entry with bit 0 clear ends it after two reads. Both give a fault.
- R5: At privilege level 3 without override, a 4 KiB page faults unless bit 2 is set in both the directory entry and the table entry. With override, the user check is skipped.
- R6: A write without override faults when the combined writable bit is clear and either the privilege level is 3 or `wpEnable` is 1. A supervisor write with `wpEnable` 0 is allowed.
- R7: On a fault the response has `rspFault`=1 and `rspPhysAddr`=all ones. `rspErrCode` bit 0 is the present bit of the failing entry, bit 1 is the write flag and bit 2 is set when the privilege level is 3. `rspFaultAddr` equals the linear address.
- R8: On success, bit 5 (accessed) is set in the directory entry. For a 4 KiB page, bit 5 and, on writes, bit 6 (dirty) are set in the table entry. For a large page the directory entry also gets bit 6 on writes. A fault writes nothing.
- R9: A request taken while `abortPending` is 1 makes no memory access. It answers on the next cycle with `rspPhysAddr`=all ones, `rspFault`=0 and `rspErrCode`=0.
- R10: `busy` is 1 from the cycle after a request is taken until the response. Requests arriving while busy are ignored. `rspValid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request, taken when idle |
| reqLinAddr | input | 32 | Linear address to translate |
| reqWrite | input | 1 | Access is a write |
| reqCpl | input | 2 | Current privilege level (3 = user) |
| reqOverride | input | 1 | Skip user and write permission checks |
| wpEnable | input | 1 | Supervisor writes obey the writable bit |
| largePageEn | input | 1 | Allow 4 MiB directory-level pages |
| abortPending | input | 1 | An abort is already pending; do not walk |
| tableBase | input | 32 | Directory base address |
| busy | output | 1 | Walk in progress |
| rspValid | output | 1 | One-cycle result strobe |
| rspPhysAddr | output | 32 | Physical address, all ones if none |
| rspFault | output | 1 | Result is a page fault |
| rspErrCode | output | 3 | {user, write, present} fault code |
| rspFaultAddr | output | 32 | Linear address of the last fault |
| memReq | output | 1 | Memory access request, held until ack |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Memory word address (byte address) |
| memWData | output | 32 | Write data |
| memAck | input | 1 | One-cycle access completion |
| memRData | input | 32 | Read data, valid with memAck |

## Verification
With the bench memory answering each access two edges after it is requested, the response latency in clock edges after the accepting edge is fixed. An abort answers after 0 edges. A directory-level fault answers after 2. A table-level fault or a large-page success answers after 4, and a full 4 KiB success after 8. The bench counts edges from the accepting edge and samples outputs at the falling edge, so it can compare the exact latency with these figures. It also logs every memory address the walker issues, which gives the access order and count. Entries are read back from the model memory once the response has arrived, because both write-backs are complete by then.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // entry flag positions (decoded by the walker and by software alike)
  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_DIRTY    = 6;
  localparam int BIT_BIGPAGE  = 7;

  typedef enum logic [1:0] {
    SEL_DIR_RD,
    SEL_TBL_RD,
    SEL_DIR_WB,
    SEL_TBL_WB
  } memSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    latchReq;
    logic    capDir;
    logic    capTbl;
    logic    ldOk;
    logic    ldFault;
    logic    ldAbort;
    logic    faultPresent;
    memSel_e memSel;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic dirPresent;
    logic dirLarge;
    logic dirDeny;
    logic tblPresent;
    logic tblDeny;
    logic walkLarge;
  } walkStatus_t;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFS_W    = 12,
  parameter int TBL_IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] reqLinAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqCpl,
  input  logic              reqOverride,
  input  logic              wpEnable,
  input  logic              largePageEn,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [ADDR_W-1:0] memRData,
  output walkStatus_t       status,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWData,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic              rspFault,
  output logic [2:0]        rspErrCode,
  output logic [ADDR_W-1:0] rspFaultAddr
);

  localparam int DIR_IDX_W    = ADDR_W - OFFS_W - TBL_IDX_W;
  localparam int BIG_OFFS_W   = OFFS_W + TBL_IDX_W;
  localparam int ENTRY_SHIFT  = $clog2(ADDR_W / 8);
  localparam logic [ADDR_W-1:0] OFFS_MASK = {{(ADDR_W-OFFS_W){1'b0}}, {OFFS_W{1'b1}}};
  localparam logic [ADDR_W-1:0] ALL_ONES  = '1;

  logic [ADDR_W-1:0] linQ, baseQ, dirQ, tblQ;
  logic              writeQ, userQ, ovrQ, wpQ, lpQ, largeQ;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ   <= '0;
      baseQ  <= '0;
      writeQ <= 1'b0;
      userQ  <= 1'b0;
      ovrQ   <= 1'b0;
      wpQ    <= 1'b0;
      lpQ    <= 1'b0;
    end else if (stb.latchReq) begin
      linQ   <= reqLinAddr;
      baseQ  <= tableBase & ~OFFS_MASK;
      writeQ <= reqWrite;
      userQ  <= (reqCpl == 2'd3);
      ovrQ   <= reqOverride;
      wpQ    <= wpEnable;
      lpQ    <= largePageEn;
    end
  end

  // entry capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ   <= '0;
      tblQ   <= '0;
      largeQ <= 1'b0;
    end else begin
      if (stb.capDir) begin
        dirQ   <= memRData;
        largeQ <= memRData[BIT_BIGPAGE] & lpQ;
      end
      if (stb.capTbl) tblQ <= memRData;
    end
  end

  // permission rule on a pair of user/writable flags
  function automatic logic denyAccess(input logic uFlag, input logic wFlag);
    logic userBad, writeBad;
    userBad  = userQ && !uFlag && !ovrQ;
    writeBad = writeQ && !wFlag && !ovrQ && (userQ || wpQ);
    return userBad || writeBad;
  endfunction

  logic [ADDR_W-1:0] combined;
  assign combined = dirQ & memRData;

  always_comb begin
    status.dirPresent = memRData[BIT_PRESENT];
    status.dirLarge   = memRData[BIT_BIGPAGE] & lpQ;
    status.dirDeny    = denyAccess(memRData[BIT_USER], memRData[BIT_WRITABLE]);
    status.tblPresent = memRData[BIT_PRESENT];
    status.tblDeny    = denyAccess(combined[BIT_USER], combined[BIT_WRITABLE]);
    status.walkLarge  = largeQ;
  end

  // address generation
  logic [ADDR_W-1:0] dirIdxOff, tblIdxOff, dirAddr, tblAddr;
  assign dirIdxOff = {{(ADDR_W-DIR_IDX_W-ENTRY_SHIFT){1'b0}},
                      linQ[ADDR_W-1 -: DIR_IDX_W], {ENTRY_SHIFT{1'b0}}};
  assign tblIdxOff = {{(ADDR_W-TBL_IDX_W-ENTRY_SHIFT){1'b0}},
                      linQ[BIG_OFFS_W-1 -: TBL_IDX_W], {ENTRY_SHIFT{1'b0}}};
  assign dirAddr   = baseQ + dirIdxOff;
  assign tblAddr   = (dirQ & ~OFFS_MASK) + tblIdxOff;

  // write-back data: set accessed, dirty on writes at the final level
  logic [ADDR_W-1:0] accMask, dirtyMask, dirWb, tblWb;
  assign accMask   = ADDR_W'(1) << BIT_ACCESSED;
  assign dirtyMask = ADDR_W'(1) << BIT_DIRTY;
  assign dirWb     = dirQ | accMask | ((largeQ && writeQ) ? dirtyMask : '0);
  assign tblWb     = tblQ | accMask | (writeQ ? dirtyMask : '0);

  always_comb begin
    memAddr  = dirAddr;
    memWData = '0;
    unique case (stb.memSel)
      SEL_DIR_RD: memAddr = dirAddr;
      SEL_TBL_RD: memAddr = tblAddr;
      SEL_DIR_WB: begin memAddr = dirAddr; memWData = dirWb; end
      SEL_TBL_WB: begin memAddr = tblAddr; memWData = tblWb; end
      default:    memAddr = dirAddr;
    endcase
  end

  // result registers
  logic [ADDR_W-1:0] okAddr;
  assign okAddr = largeQ ? {dirQ[ADDR_W-1:BIG_OFFS_W], linQ[BIG_OFFS_W-1:0]}
                         : {tblQ[ADDR_W-1:OFFS_W], linQ[OFFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPhysAddr  <= ALL_ONES;
      rspFault     <= 1'b0;
      rspErrCode   <= '0;
      rspFaultAddr <= '0;
    end else if (stb.ldOk) begin
      rspPhysAddr <= okAddr;
      rspFault    <= 1'b0;
      rspErrCode  <= '0;
    end else if (stb.ldFault) begin
      rspPhysAddr  <= ALL_ONES;
      rspFault     <= 1'b1;
      rspErrCode   <= {userQ, writeQ, stb.faultPresent};
      rspFaultAddr <= linQ;
    end else if (stb.ldAbort) begin
      rspPhysAddr <= ALL_ONES;
      rspFault    <= 1'b0;
      rspErrCode  <= '0;
    end
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        abortPending,
  input  logic        memAck,
  input  walkStatus_t status,
  output ctrlStrobe_t stb,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output logic        rspValid
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_TBL_RD, ST_DIR_WB, ST_TBL_WB, ST_DONE
  } walkState_e;

  walkState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '{latchReq: 1'b0, capDir: 1'b0, capTbl: 1'b0, ldOk: 1'b0,
                  ldFault: 1'b0, ldAbort: 1'b0, faultPresent: 1'b0,
                  memSel: SEL_DIR_RD};
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stb.latchReq = 1'b1;
          stb.ldAbort  = abortPending;
          nextState    = abortPending ? ST_DONE : ST_DIR_RD;
        end
      end
      ST_DIR_RD: begin
        memReq     = 1'b1;
        stb.memSel = SEL_DIR_RD;
        if (memAck) begin
          stb.capDir = 1'b1;
          if (!status.dirPresent) begin
            stb.ldFault = 1'b1;
            nextState   = ST_DONE;
          end else if (status.dirLarge) begin
            if (status.dirDeny) begin
              stb.ldFault      = 1'b1;
              stb.faultPresent = 1'b1;
              nextState        = ST_DONE;
            end else begin
              nextState = ST_DIR_WB;
            end
          end else begin
            nextState = ST_TBL_RD;
          end
        end
      end
      ST_TBL_RD: begin
        memReq     = 1'b1;
        stb.memSel = SEL_TBL_RD;
        if (memAck) begin
          stb.capTbl = 1'b1;
          if (!status.tblPresent) begin
            stb.ldFault = 1'b1;
            nextState   = ST_DONE;
          end else if (status.tblDeny) begin
            stb.ldFault      = 1'b1;
            stb.faultPresent = 1'b1;
            nextState        = ST_DONE;
          end else begin
            nextState = ST_DIR_WB;
          end
        end
      end
      ST_DIR_WB: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        stb.memSel = SEL_DIR_WB;
        if (memAck) begin
          if (status.walkLarge) begin
            stb.ldOk  = 1'b1;
            nextState = ST_DONE;
          end else begin
            nextState = ST_TBL_WB;
          end
        end
      end
      ST_TBL_WB: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        stb.memSel = SEL_TBL_WB;
        if (memAck) begin
          stb.ldOk  = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign rspValid = (state == ST_DONE);

  // R10
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(rspValid));

  // R9
  abort_no_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && abortPending) |=> (rspValid && !memReq));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFS_W    = 12,
  parameter int TBL_IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqLinAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqCpl,
  input  logic              reqOverride,
  input  logic              wpEnable,
  input  logic              largePageEn,
  input  logic              abortPending,
  input  logic [ADDR_W-1:0] tableBase,
  output logic              busy,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPhysAddr,
  output logic              rspFault,
  output logic [2:0]        rspErrCode,
  output logic [ADDR_W-1:0] rspFaultAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWData,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memRData
);

  ctrlStrobe_t stb;
  walkStatus_t status;

  ptw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .abortPending (abortPending),
    .memAck       (memAck),
    .status       (status),
    .stb          (stb),
    .memReq       (memReq),
    .memWe        (memWe),
    .busy         (busy),
    .rspValid     (rspValid)
  );

  ptw_datapath #(
    .ADDR_W    (ADDR_W),
    .OFFS_W    (OFFS_W),
    .TBL_IDX_W (TBL_IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .reqLinAddr   (reqLinAddr),
    .reqWrite     (reqWrite),
    .reqCpl       (reqCpl),
    .reqOverride  (reqOverride),
    .wpEnable     (wpEnable),
    .largePageEn  (largePageEn),
    .tableBase    (tableBase),
    .memRData     (memRData),
    .status       (status),
    .memAddr      (memAddr),
    .memWData     (memWData),
    .rspPhysAddr  (rspPhysAddr),
    .rspFault     (rspFault),
    .rspErrCode   (rspErrCode),
    .rspFaultAddr (rspFaultAddr)
  );

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R7
  fault_addr_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPhysAddr == '1));

  // R8
  wb_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memWData[BIT_PRESENT] && memWData[BIT_ACCESSED]));

endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqLinAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqCpl = 2'd0;
  logic        reqOverride = 1'b0;
  logic        wpEnable = 1'b0;
  logic        largePageEn = 1'b0;
  logic        abortPending = 1'b0;
  logic [31:0] tableBase = 32'h0000_1ABC;
  logic        busy, rspValid, rspFault, memReq, memWe;
  logic [31:0] rspPhysAddr, rspFaultAddr, memAddr, memWData;
  logic [2:0]  rspErrCode;
  logic        memAck = 1'b0;
  logic [31:0] memRData = '0;

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLinAddr(reqLinAddr),
    .reqWrite(reqWrite), .reqCpl(reqCpl), .reqOverride(reqOverride),
    .wpEnable(wpEnable), .largePageEn(largePageEn), .abortPending(abortPending),
    .tableBase(tableBase), .busy(busy), .rspValid(rspValid),
    .rspPhysAddr(rspPhysAddr), .rspFault(rspFault), .rspErrCode(rspErrCode),
    .rspFaultAddr(rspFaultAddr), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .memAck(memAck), .memRData(memRData)
  );

  // memory model: answers two edges after a request, logs addresses
  logic [31:0] mem [0:4095];
  logic [31:0] addrLog [0:15];
  int          logCnt = 0;
  logic        clrLog = 1'b0;
  logic        pkEn = 1'b0;
  logic [31:0] pkAddr = '0, pkData = '0;

  always @(posedge clk) begin
    if (pkEn) mem[pkAddr[13:2]] <= pkData;
    if (clrLog) logCnt <= 0;
    if (memReq && !memAck) begin
      memAck   <= 1'b1;
      memRData <= mem[memAddr[13:2]];
      if (memWe) mem[memAddr[13:2]] <= memWData;
      if (logCnt < 16) addrLog[logCnt] <= memAddr;
      logCnt <= logCnt + 1;
    end else begin
      memAck <= 1'b0;
    end
  end

  int total = 0, bad = 0;
  logic [31:0] gotPa, gotFa;
  logic        gotFault;
  logic [2:0]  gotErr;
  int          gotLat;
  bit          finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pokeMem(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    pkEn = 1'b1; pkAddr = a; pkData = d;
    @(negedge clk);
    pkEn = 1'b0;
  endtask

  // issue one request; latency = edges after the accepting edge
  task automatic runXlate(input logic [31:0] lin, input logic wr, input logic [1:0] cpl,
                          input logic ovr, input bit holdReq);
    @(negedge clk);
    reqValid = 1'b1; reqLinAddr = lin; reqWrite = wr; reqCpl = cpl; reqOverride = ovr;
    clrLog = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clrLog = 1'b0;
    if (holdReq) reqLinAddr = lin ^ 32'h0040_0000;
    else reqValid = 1'b0;
    gotLat = 0;
    while (!rspValid && gotLat < 60) begin
      @(posedge clk); gotLat++; @(negedge clk);
      if (holdReq && !rspValid) check("R10 busy during walk", {31'd0, busy}, 32'd1);
    end
    if (!rspValid) check("R10 response timeout", 32'd0, 32'd1);
    gotPa = rspPhysAddr; gotFault = rspFault; gotErr = rspErrCode; gotFa = rspFaultAddr;
    reqValid = 1'b0;
  endtask

  task automatic testReset();
    check("R10 reset busy", {31'd0, busy}, 32'd0);
    check("R10 reset rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 reset memReq", {31'd0, memReq}, 32'd0);
  endtask

  task automatic testSmallRead();
    runXlate(32'h00C0_5123, 1'b0, 2'd0, 1'b0, 0);
    check("R2 small read pa", gotPa, 32'hABCD_E123);
    check("R2 small read fault", {31'd0, gotFault}, 32'd0);
    check("R10 small latency", gotLat, 32'd8);
    check("R1 dir addr", addrLog[0], 32'h0000_100C);
    check("R1 tbl addr", addrLog[1], 32'h0000_2014);
    check("R1 access count", logCnt, 32'd4);
    check("R8 dir accessed", mem[12'h403], 32'h0000_2027);
    check("R8 tbl accessed no dirty", mem[12'h805], 32'hABCD_E027);
  endtask

  task automatic testSmallWrite();
    runXlate(32'h00C0_5FFC, 1'b1, 2'd3, 1'b0, 0);
    check("R2 small write pa", gotPa, 32'hABCD_EFFC);
    check("R8 tbl dirty", mem[12'h805], 32'hABCD_E067);
    check("R8 dir no dirty", mem[12'h403], 32'h0000_2027);
  endtask

  task automatic testLarge();
    largePageEn = 1'b1;
    runXlate(32'h01C2_ABCD, 1'b1, 2'd3, 1'b0, 0);
    check("R3 large pa", gotPa, 32'h12C2_ABCD);
    check("R3 large latency", gotLat, 32'd4);
    check("R3 large access count", logCnt, 32'd2);
    check("R8 large dir acc+dirty", mem[12'h407], 32'h12C0_00E7);
    // large entry without user/write bits
    runXlate(32'h0340_1234, 1'b0, 2'd3, 1'b0, 0);
    check("R3 large deny fault", {31'd0, gotFault}, 32'd1);
    check("R7 large deny code", {29'd0, gotErr}, 32'd5);
    check("R3 large deny latency", gotLat, 32'd2);
    check("R8 large deny untouched", mem[12'h40D], 32'h0040_0081);
    largePageEn = 1'b0;
    runXlate(32'h0200_5456, 1'b0, 2'd0, 1'b0, 0);
    check("R3 size bit ignored pa", gotPa, 32'hABCD_E456);
    check("R3 size bit ignored latency", gotLat, 32'd8);
  endtask

  task automatic testNotPresent();
    runXlate(32'h0240_0789, 1'b1, 2'd3, 1'b0, 0);
    check("R4 dir absent fault", {31'd0, gotFault}, 32'd1);
    check("R7 dir absent code", {29'd0, gotErr}, 32'd6);
    check("R7 dir absent pa", gotPa, 32'hFFFF_FFFF);
    check("R7 fault addr", gotFa, 32'h0240_0789);
    check("R4 dir absent latency", gotLat, 32'd2);
    check("R4 single access", logCnt, 32'd1);
    runXlate(32'h0280_9000, 1'b0, 2'd0, 1'b0, 0);
    check("R4 tbl absent fault", {31'd0, gotFault}, 32'd1);
    check("R7 tbl absent code", {29'd0, gotErr}, 32'd0);
    check("R4 tbl absent latency", gotLat, 32'd4);
    check("R8 no write on fault", mem[12'h40A], 32'h0000_2007);
  endtask

  task automatic testUser();
    runXlate(32'h02C0_5000, 1'b0, 2'd3, 1'b0, 0);
    check("R5 combined user deny", {31'd0, gotFault}, 32'd1);
    check("R7 user deny code", {29'd0, gotErr}, 32'd5);
    check("R8 dir untouched on deny", mem[12'h40B], 32'h0000_2003);
    runXlate(32'h02C0_5000, 1'b0, 2'd3, 1'b1, 0);
    check("R5 override pa", gotPa, 32'hABCD_E000);
    check("R5 override fault", {31'd0, gotFault}, 32'd0);
    check("R8 dir accessed after ok", mem[12'h40B], 32'h0000_2023);
  endtask

  task automatic testWriteProtect();
    wpEnable = 1'b1;
    runXlate(32'h0300_5010, 1'b1, 2'd0, 1'b0, 0);
    check("R6 supervisor write wp on", {31'd0, gotFault}, 32'd1);
    check("R7 wp code", {29'd0, gotErr}, 32'd3);
    wpEnable = 1'b0;
    runXlate(32'h0300_5010, 1'b1, 2'd0, 1'b0, 0);
    check("R6 supervisor write wp off", gotPa, 32'hABCD_E010);
    runXlate(32'h0300_5010, 1'b1, 2'd3, 1'b0, 0);
    check("R6 user write denied", {29'd0, gotErr}, 32'd7);
    check("R6 user write fault", {31'd0, gotFault}, 32'd1);
  endtask

  task automatic testAbort();
    abortPending = 1'b1;
    runXlate(32'h00C0_5123, 1'b0, 2'd0, 1'b0, 0);
    abortPending = 1'b0;
    check("R9 abort pa", gotPa, 32'hFFFF_FFFF);
    check("R9 abort fault", {31'd0, gotFault}, 32'd0);
    check("R9 abort code", {29'd0, gotErr}, 32'd0);
    check("R9 abort latency", gotLat, 32'd0);
    check("R9 no memory access", logCnt, 32'd0);
  endtask

  task automatic testBusyIgnore();
    runXlate(32'h00C0_5ABC, 1'b0, 2'd0, 1'b0, 1);
    check("R10 held request result", gotPa, 32'hABCD_EABC);
    check("R10 held latency", gotLat, 32'd8);
    @(negedge clk);
    check("R10 pulse ends", {31'd0, rspValid}, 32'd0);
    check("R10 idle after", {31'd0, busy}, 32'd0);
    check("R10 held count", logCnt, 32'd4);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R10 watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    pokeMem(32'h100C, 32'h0000_2007);
    pokeMem(32'h2014, 32'hABCD_E007);
    pokeMem(32'h101C, 32'h12C0_0087);
    pokeMem(32'h1034, 32'h0040_0081);
    pokeMem(32'h1020, 32'h0000_20A7);
    pokeMem(32'h1024, 32'h0000_0000);
    pokeMem(32'h1028, 32'h0000_2007);
    pokeMem(32'h2024, 32'h0000_0000);
    pokeMem(32'h102C, 32'h0000_2003);
    pokeMem(32'h1030, 32'h0000_2005);
    testSmallRead();
    testSmallWrite();
    testLarge();
    testNotPresent();
    testUser();
    testWriteProtect();
    testAbort();
    testBusyIgnore();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule